// File: doc/BRIEF.md
# Effective Address Generator

This block forms the addresses used by a small load-store processor. Each request supplies a base register value, an 8-bit signed offset, an operation kind and two modifiers. Loads and stores produce a memory request. An address-only operation produces a result for the destination register and never produces a memory request. An optional post-increment advances the base register by the access size after the access. An optional pointer-tag strip clears the low 3 or 4 bits of the base before the address is formed.

All outputs are registered. A valid request presented on one rising edge appears on the outputs after that edge. When no valid request is presented, the outputs go quiet on the next edge.

Top module: `ls_agu`

## Requirements
- R1: A load or store request sets `mem_addr` to the 32-bit sum of the base and the offset, modulo 2^32. The offset is sign-extended, so the code 0xF0 stands for -16.
- R2: The address sum wraps modulo 2^32 and raises no flag. For example, base 0xFFFFFFF8 with offset 0x10 gives address 0x00000008.
- R3: Operation codes are `op_i`=0 for load, 1 for store and 2 for address-only. A load or store raises `mem_valid` and drives `mem_write` to 1 for a store and 0 for a load.
- R4: An address-only request (code 2) leaves `mem_valid` low. It raises `dst_valid`, and `dst_value` equals base plus the sign-extended offset with no tag stripping.
- R5: When `tag_en_i` is high on a load or store, the low tag bits of the base are cleared before the offset is added. There are 3 tag bits when `tag_wide_i` is 0 and 4 when it is 1.
- R6: Tag stripping never changes the register writeback. `wb_value` is the unmasked base plus the step, and `dst_value` ignores `tag_en_i`.
- R7: When `postinc_i` is high on a load or store, `wb_valid` rises and `wb_value` equals base + (1 << `size_i`). The size codes 0, 1, 2 and 3 give steps of 1, 2, 4 and 8. The memory address uses the base before the increment.
- R8: The outputs appear one clock after a valid input. A cycle without `req_valid_i` leaves `mem_valid`, `dst_valid` and `wb_valid` low on the next edge.
- R9: After reset, all valid outputs are low and all data outputs are zero.
- R10: Operation code 3 is treated as idle. It raises no valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| op_i | input | 2 | 0 load, 1 store, 2 address-only, 3 idle |
| base_i | input | 32 | Base register value |
| disp_i | input | 8 | Signed offset |
| postinc_i | input | 1 | Post-increment enable |
| size_i | input | 2 | Access size as log2 of the byte count |
| tag_en_i | input | 1 | Strip pointer tag from the address |
| tag_wide_i | input | 1 | 0: 3 tag bits, 1: 4 tag bits |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | Request is a store |
| mem_addr | output | 32 | Memory address |
| dst_valid | output | 1 | Address-only result |
| dst_value | output | 32 | Destination register value |
| wb_valid | output | 1 | Base writeback present |
| wb_value | output | 32 | New base value |

## Verification
The bench sweeps every offset code against base values chosen near the wrap point, near zero and with tag bits set. A design that zero-extended the offset would send negative offsets far above the base. A design that carried the wrap would corrupt the high bits. The bench also crosses the tag enable, the tag width, the post-increment flag and each size. A design that applied the mask to the writeback, or incremented before the access, would show a wrong `wb_value` or `mem_addr`. Address-only and idle codes are checked for a quiet memory request, and idle cycles are checked for dropped valid flags.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 8;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CALC  = 2'd2,
    OP_IDLE  = 2'd3
  } agu_op_e;
  typedef struct packed {
    logic          mem_valid;
    logic          mem_write;
    logic [AW-1:0] mem_addr;
    logic          dst_valid;
    logic [AW-1:0] dst_value;
    logic          wb_valid;
    logic [AW-1:0] wb_value;
  } agu_out_t;
endpackage

// File: rtl/ls_agu_ext.sv
module ls_agu_ext #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  disp_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int unsigned PAD = OUT_W - IN_W;
  always_comb begin
    ext_o = {{PAD{disp_i[IN_W-1]}}, disp_i};
  end
endmodule

// File: rtl/ls_agu_mask.sv
module ls_agu_mask #(
  parameter int unsigned AW     = 32,
  parameter int unsigned NARROW = 3,
  parameter int unsigned WIDE   = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic          en_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_base_o
);
  localparam logic [AW-1:0] KEEP_N = ~((AW'(1) << NARROW) - AW'(1));
  localparam logic [AW-1:0] KEEP_W = ~((AW'(1) << WIDE) - AW'(1));
  always_comb begin
    if (!en_i)       addr_base_o = base_i;
    else if (wide_i) addr_base_o = base_i & KEEP_W;
    else             addr_base_o = base_i & KEEP_N;
  end
endmodule

// File: rtl/ls_agu_step.sv
module ls_agu_step #(
  parameter int unsigned AW    = 32,
  parameter int unsigned SZ_W  = 2
) (
  input  logic [AW-1:0]   base_i,
  input  logic [SZ_W-1:0] size_i,
  output logic [AW-1:0]   next_o
);
  localparam int unsigned NSZ = 1 << SZ_W;
  logic [AW-1:0] steps [NSZ];
  for (genvar g = 0; g < NSZ; g++) begin : g_step
    assign steps[g] = AW'(1) << g;
  end
  always_comb begin
    next_o = base_i + steps[size_i];
  end
endmodule

// File: rtl/ls_agu.sv
module ls_agu
  import ls_agu_pkg::*;
#(
  parameter int unsigned TAG_NARROW = 3,
  parameter int unsigned TAG_WIDE   = 4,
  parameter int unsigned SZ_W       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   base_i,
  input  logic [DW-1:0]   disp_i,
  input  logic            postinc_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            tag_en_i,
  input  logic            tag_wide_i,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic            dst_valid,
  output logic [AW-1:0]   dst_value,
  output logic            wb_valid,
  output logic [AW-1:0]   wb_value
);
  logic [AW-1:0] disp_ext, addr_base, base_next;
  agu_out_t      nxt, cur;
  logic          is_mem, is_calc, upd_en;

  ls_agu_ext #(.IN_W(DW), .OUT_W(AW)) u_ext (.disp_i(disp_i), .ext_o(disp_ext));
  ls_agu_mask #(.AW(AW), .NARROW(TAG_NARROW), .WIDE(TAG_WIDE)) u_mask (
    .base_i(base_i), .en_i(tag_en_i), .wide_i(tag_wide_i), .addr_base_o(addr_base));
  ls_agu_step #(.AW(AW), .SZ_W(SZ_W)) u_step (
    .base_i(base_i), .size_i(size_i), .next_o(base_next));

  always_comb begin
    is_mem  = req_valid_i && (op_i == OP_LOAD || op_i == OP_STORE);
    is_calc = req_valid_i && (op_i == OP_CALC);
    nxt.mem_valid = is_mem;
    nxt.mem_write = is_mem && (op_i == OP_STORE);
    nxt.mem_addr  = is_mem ? addr_base + disp_ext : cur.mem_addr;
    nxt.dst_valid = is_calc;
    nxt.dst_value = is_calc ? base_i + disp_ext : cur.dst_value;
    nxt.wb_valid  = is_mem && postinc_i;
    nxt.wb_value  = (is_mem && postinc_i) ? base_next : cur.wb_value;
    upd_en = req_valid_i || cur.mem_valid || cur.dst_valid || cur.wb_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur <= '0;
    else if (upd_en) cur <= nxt;
  end

  assign mem_valid = cur.mem_valid;
  assign mem_write = cur.mem_write;
  assign mem_addr  = cur.mem_addr;
  assign dst_valid = cur.dst_valid;
  assign dst_value = cur.dst_value;
  assign wb_valid  = cur.wb_valid;
  assign wb_value  = cur.wb_value;
endmodule

// File: rtl/ls_agu_chk.sv
module ls_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic [1:0]  op_i,
  input logic [31:0] base_i,
  input logic [7:0]  disp_i,
  input logic        postinc_i,
  input logic        tag_en_i,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic        dst_valid,
  input logic [31:0] dst_value,
  input logic        wb_valid
);
  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && dst_valid));
  assert_wb_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mem_valid);
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !(mem_valid || dst_valid || wb_valid));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i == 2'd3) |=> !(mem_valid || dst_valid));
  assert_calc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i == 2'd2) |=>
      (dst_valid && dst_value == $past(base_i) + {{24{$past(disp_i[7])}}, $past(disp_i)}));
  assert_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i[1] == 1'b0 && !tag_en_i) |=>
      (mem_valid && mem_addr == $past(base_i) + {{24{$past(disp_i[7])}}, $past(disp_i)}));
  assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i == 2'd1) |=> (mem_valid && mem_write));
  assert_postinc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && op_i[1] == 1'b0 && postinc_i) |=> wb_valid);
endmodule

bind ls_agu ls_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .op_i(op_i),
  .base_i(base_i), .disp_i(disp_i), .postinc_i(postinc_i), .tag_en_i(tag_en_i),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
  .dst_valid(dst_valid), .dst_value(dst_value), .wb_valid(wb_valid));

// File: tb/test_ls_agu.sv
module test_ls_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [1:0]  op_i;
  logic [31:0] base_i;
  logic [7:0]  disp_i;
  logic        postinc_i;
  logic [1:0]  size_i;
  logic        tag_en_i, tag_wide_i;
  logic        mem_valid, mem_write, dst_valid, wb_valid;
  logic [31:0] mem_addr, dst_value, wb_value;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ls_agu i_ls_agu (.*);

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] b,
                       input logic [7:0] d, input logic pi, input logic [1:0] sz,
                       input logic te, input logic tw);
    @(negedge clk);
    req_valid_i = v; op_i = op; base_i = b; disp_i = d;
    postinc_i = pi; size_i = sz; tag_en_i = te; tag_wide_i = tw;
    @(negedge clk);
  endtask

  function automatic logic [31:0] sext(input logic [7:0] d);
    int s = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    return 32'(s);
  endfunction

  initial begin
    logic [31:0] bases [4];
    bases[0] = 32'h0000_0000; bases[1] = 32'hFFFF_FFF8;
    bases[2] = 32'h1234_567F; bases[3] = 32'h8000_0005;
    rst_n = 1'b0;
    req_valid_i = 0; op_i = 0; base_i = 0; disp_i = 0;
    postinc_i = 0; size_i = 0; tag_en_i = 0; tag_wide_i = 0;
    #20;
    chk("R9 mem_valid", {31'b0, mem_valid}, 0);
    chk("R9 dst_valid", {31'b0, dst_valid}, 0);
    chk("R9 wb_valid", {31'b0, wb_valid}, 0);
    chk("R9 mem_addr", mem_addr, 0);
    chk("R9 wb_value", wb_value, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int bi = 0; bi < 4; bi++) begin
      for (int d = 0; d < 256; d++) begin
        logic [31:0] b = bases[bi];
        drive(1, 2'd0, b, 8'(d), 0, 0, 0, 0);
        chk("R1 address", mem_addr, b + sext(8'(d)));
        chk("R3 load valid", {30'b0, mem_valid, mem_write}, 32'd2);
        drive(1, 2'd2, b, 8'(d), 0, 0, 1, 1);
        chk("R4 calc value", dst_value, b + sext(8'(d)));
        chk("R4 calc no mem", {30'b0, mem_valid, dst_valid}, 32'd1);
      end
    end

    drive(1, 2'd1, 32'h0000_1000, 8'hF0, 0, 0, 0, 0);
    chk("R1 negative 0xF0", mem_addr, 32'h0000_0FF0);
    chk("R3 store flag", {31'b0, mem_write}, 1);
    drive(1, 2'd0, 32'hFFFF_FFF8, 8'h10, 0, 0, 0, 0);
    chk("R2 wrap", mem_addr, 32'h0000_0008);
    drive(1, 2'd1, 32'h0000_0004, 8'h80, 0, 0, 0, 0);
    chk("R2 wrap down", mem_addr, 32'hFFFF_FF84);

    for (int t = 0; t < 4; t++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int bi = 0; bi < 4; bi++) begin
          logic [31:0] b = bases[bi] | 32'hF;
          logic [31:0] mb;
          logic te = t[1], tw = t[0];
          mb = !te ? b : (tw ? b & ~32'hF : b & ~32'h7);
          drive(1, 2'(bi & 1), b, 8'h05, 1, 2'(sz), te, tw);
          chk("R5 tag strip address", mem_addr, mb + 32'd5);
          chk("R7 wb_valid", {31'b0, wb_valid}, 1);
          chk("R6 R7 writeback unmasked", wb_value, b + (32'd1 << sz));
          drive(1, 2'd2, b, 8'h05, 1, 2'(sz), te, tw);
          chk("R6 calc ignores tag", dst_value, b + 32'd5);
          chk("R7 no wb on calc", {31'b0, wb_valid}, 0);
        end
      end
    end

    drive(1, 2'd0, 32'h100, 8'h0, 1, 2'd2, 0, 0);
    drive(0, 2'd0, 32'h200, 8'h4, 1, 2'd2, 0, 0);
    chk("R8 idle drops valids", {29'b0, mem_valid, dst_valid, wb_valid}, 0);
    drive(1, 2'd3, 32'h300, 8'h4, 1, 2'd2, 0, 0);
    chk("R10 code 3 idle", {29'b0, mem_valid, dst_valid, wb_valid}, 0);
    drive(1, 2'd1, 32'h400, 8'h8, 0, 2'd0, 0, 0);
    chk("R8 one cycle latency", mem_addr, 32'h408);
    chk("R7 no wb without postinc", {31'b0, wb_valid}, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule